// File: doc/BRIEF.md
# Audio Clock Generator and Frame-Phase Monitor

This block runs from a master clock at 256 times the audio sample rate. Its job depends on the mode pin. In master mode it divides the master clock down to a bit clock at 64 Fs and a frame clock at Fs, and it passes the master clock out to the rest of the system. In slave mode the bit and frame clocks come from outside. The master clock output is then held low, and the block checks that the external frame clock stays phase-locked to the master clock.

Phase tracking works from a free-running modulo-256 master-clock counter. The counter value is stamped at every rising edge of the frame clock. Each stamp is compared with the one before, using a signed wrap-around difference. If the difference exceeds a fixed tolerance, or if no frame edge arrives within a time-out window, the block raises a one-cycle resynchronisation request and holds its error output high. The error output falls again only after a fresh reference edge followed by two consecutive in-tolerance frames. The control sequencer uses these outputs to hold the audio path in hard mute and to restart it.

There is no data stream through this block. All pins are plain control and status levels, except the resynchronisation request, which is a single-cycle pulse.

Top module: `audio_clk_gen`

## Requirements
- R1: In master mode after reset, the bit clock is high during master-clock counts 2 and 3 of every 4, and the frame clock is high during counts 0 to 127 of every 256. Both therefore have 50% duty. The count is 0 during reset and increases by 1 on each clock edge after reset is released.
- R2: In master mode, every rising edge of the frame clock falls on the same master-clock edge as a falling edge of the bit clock.
- R3: The master clock output follows the master clock in master mode (master_sel = 1) and is constant low in slave mode (master_sel = 0). In slave mode the bit and frame clock outputs are held low.
- R4: In slave mode the error output is high from reset until lock is reached.
- R5: Lock needs a reference frame-clock rising edge followed by exactly two consecutive in-tolerance frames. After only one good frame, the error output is still high.
- R6: A change in frame length of up to ±10 master-clock periods is tolerated, measured modulo 256 between consecutive frame rising edges and including counter wrap-around. It causes no request and no error.
- R7: A change of more than 10 periods in either direction raises resync_req for exactly one cycle and sets the error output. Relocking then needs two further good frames, measured from the slipped edge.
- R8: If no frame-clock rising edge arrives for 512 master-clock cycles, the block sets clk_lost and the error output, and pulses resync_req once. The next rising edge clears clk_lost and serves only as a new reference.
- R9: In master mode, err, clk_lost and resync_req stay low whatever fclk_in does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 256 Fs |
| rst_n | input | 1 | Active-low reset, synchronous release |
| master_sel | input | 1 | 1 = generate clocks, 0 = accept external clocks |
| fclk_in | input | 1 | External frame clock (slave mode) |
| mclk_out | output | 1 | Master clock out, low in slave mode |
| bclk_out | output | 1 | Generated bit clock, 64 Fs |
| fclk_out | output | 1 | Generated frame clock, Fs |
| err | output | 1 | Clock error, high until locked |
| clk_lost | output | 1 | Frame clock missing |
| resync_req | output | 1 | One-cycle reset request on slip or loss |

## Verification
A corrupted divider counter appears at the next negative clock edge as a wrong bit-clock or frame-clock level. The scoreboard compares every cycle against a count derived from the number of clock edges since reset. A wrong stored reference stamp or a miscounted good-frame tally appears one frame later, as a spurious resync pulse or as an error that falls one frame early or late. The bench therefore checks the error level after every frame of a scripted sequence of ±10 and ±11 length changes. A broken time-out counter appears as clk_lost rising at the wrong time, or as the error output clearing before a new reference edge.

// File: rtl/acg_pkg.sv
package acg_pkg;
  typedef enum logic [1:0] {
    MON_NOREF   = 2'd0,
    MON_LOCKING = 2'd1,
    MON_LOCKED  = 2'd2
  } mon_state_e;
endpackage

// File: rtl/acg_divider.sv
module acg_divider #(
  parameter int RATIO_LOG2 = 8,
  parameter int BCLK_LOG2  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic [RATIO_LOG2-1:0] phase,
  output logic                  bclk,
  output logic                  fclk
);
  // Free-running count; also the phase reference for slave monitoring.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase + 1'b1;
  end

  // The bit clock falls as the count wraps to 0, where the frame clock rises.
  assign bclk = phase[BCLK_LOG2-1];
  assign fclk = ~phase[RATIO_LOG2-1];
endmodule

// File: rtl/acg_edge_stamp.sv
module acg_edge_stamp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         fclk_in,
  input  logic [W-1:0] phase,
  output logic         rise,
  output logic [W-1:0] stamp
);
  logic f_q1, f_q2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_q1 <= 1'b0;
      f_q2 <= 1'b0;
    end else if (!en) begin
      f_q1 <= 1'b0;
      f_q2 <= 1'b0;
    end else begin
      f_q1 <= fclk_in;
      f_q2 <= f_q1;
    end
  end

  assign rise  = f_q1 & ~f_q2;
  assign stamp = phase;
endmodule

// File: rtl/acg_watchdog.sv
module acg_watchdog #(
  parameter int TIMEOUT = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rise,
  output logic lost,
  output logic expire
);
  localparam int WD_W = $clog2(TIMEOUT);
  localparam logic [WD_W-1:0] WD_LAST = WD_W'(TIMEOUT - 1);

  logic [WD_W-1:0] wd;

  assign expire = en & ~lost & ~rise & (wd == WD_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd   <= '0;
      lost <= 1'b0;
    end else if (!en || rise) begin
      wd   <= '0;
      lost <= 1'b0;
    end else if (expire) begin
      lost <= 1'b1;
    end else if (!lost) begin
      wd <= wd + 1'b1;
    end
  end
endmodule

// File: rtl/acg_phase_check.sv
module acg_phase_check
  import acg_pkg::*;
#(
  parameter int W           = 8,
  parameter int TOL         = 10,
  parameter int LOCK_FRAMES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         rise,
  input  logic [W-1:0] stamp,
  input  logic         expire,
  output logic         err,
  output logic         resync
);
  localparam int GW = $clog2(LOCK_FRAMES + 1);
  localparam logic [GW-1:0] GOOD_LAST = GW'(LOCK_FRAMES - 1);

  mon_state_e     state;
  logic [W-1:0]   ref_stamp;
  logic [GW-1:0]  good;
  logic [W-1:0]   diff;
  logic [W:0]     delta;
  logic [W:0]     mag;
  logic           slip;

  // Signed modulo-2^W distance between consecutive stamps.
  always_comb begin
    diff  = stamp - ref_stamp;
    delta = {diff[W-1], diff};
    mag   = delta[W] ? (~delta + 1'b1) : delta;
    slip  = (mag > (W+1)'(TOL));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= MON_NOREF;
      ref_stamp <= '0;
      good      <= '0;
      resync    <= 1'b0;
    end else if (!en) begin
      state     <= MON_NOREF;
      ref_stamp <= '0;
      good      <= '0;
      resync    <= 1'b0;
    end else begin
      resync <= 1'b0;
      if (expire) begin
        state  <= MON_NOREF;
        good   <= '0;
        resync <= 1'b1;
      end else if (rise) begin
        ref_stamp <= stamp;
        unique case (state)
          MON_NOREF: begin
            state <= MON_LOCKING;
            good  <= '0;
          end
          MON_LOCKING: begin
            if (slip) begin
              good   <= '0;
              resync <= 1'b1;
            end else if (good == GOOD_LAST) begin
              good  <= '0;
              state <= MON_LOCKED;
            end else begin
              good <= good + 1'b1;
            end
          end
          MON_LOCKED: begin
            if (slip) begin
              state  <= MON_LOCKING;
              good   <= '0;
              resync <= 1'b1;
            end
          end
          default: state <= MON_NOREF;
        endcase
      end
    end
  end

  assign err = en & (state != MON_LOCKED);
endmodule

// File: rtl/audio_clk_gen.sv
module audio_clk_gen #(
  parameter int RATIO_LOG2  = 8,
  parameter int BCLK_LOG2   = 2,
  parameter int PHASE_TOL   = 10,
  parameter int TIMEOUT     = 512,
  parameter int LOCK_FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master_sel,
  input  logic fclk_in,
  output logic mclk_out,
  output logic bclk_out,
  output logic fclk_out,
  output logic err,
  output logic clk_lost,
  output logic resync_req
);
  logic [RATIO_LOG2-1:0] phase;
  logic [RATIO_LOG2-1:0] stamp;
  logic                  div_bclk, div_fclk;
  logic                  mon_en, rise, expire;

  assign mon_en = ~master_sel;

  acg_divider #(.RATIO_LOG2(RATIO_LOG2), .BCLK_LOG2(BCLK_LOG2)) u_div (
    .clk(clk), .rst_n(rst_n), .phase(phase), .bclk(div_bclk), .fclk(div_fclk)
  );

  acg_edge_stamp #(.W(RATIO_LOG2)) u_stamp (
    .clk(clk), .rst_n(rst_n), .en(mon_en), .fclk_in(fclk_in),
    .phase(phase), .rise(rise), .stamp(stamp)
  );

  acg_watchdog #(.TIMEOUT(TIMEOUT)) u_wd (
    .clk(clk), .rst_n(rst_n), .en(mon_en), .rise(rise),
    .lost(clk_lost), .expire(expire)
  );

  acg_phase_check #(.W(RATIO_LOG2), .TOL(PHASE_TOL), .LOCK_FRAMES(LOCK_FRAMES)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(mon_en), .rise(rise), .stamp(stamp),
    .expire(expire), .err(err), .resync(resync_req)
  );

  assign mclk_out = clk & master_sel;
  assign bclk_out = div_bclk & master_sel;
  assign fclk_out = div_fclk & master_sel;
endmodule

// File: rtl/acg_checker.sv
module acg_checker (
  input logic clk,
  input logic rst_n,
  input logic master_sel,
  input logic bclk_out,
  input logic fclk_out,
  input logic err,
  input logic clk_lost,
  input logic resync_req
);
  assert_slave_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !master_sel |-> (!bclk_out && !fclk_out));

  assert_frame_on_bit_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (master_sel && $rose(fclk_out)) |-> $fell(bclk_out));

  assert_master_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    master_sel |-> (!err && !clk_lost && !resync_req));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resync_req |=> !resync_req);

  assert_loss_requests_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_lost) |-> (err && resync_req));

  assert_lost_means_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_lost |-> err);

  assert_lock_with_clock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> (!clk_lost && !master_sel));
endmodule

bind audio_clk_gen acg_checker u_acg_checker (
  .clk(clk), .rst_n(rst_n), .master_sel(master_sel), .bclk_out(bclk_out),
  .fclk_out(fclk_out), .err(err), .clk_lost(clk_lost), .resync_req(resync_req)
);

// File: tb/sim_audio_clk_gen.sv
module sim_audio_clk_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_sel = 1'b1;
  logic fclk_in = 1'b0;
  logic mclk_out, bclk_out, fclk_out, err, clk_lost, resync_req;

  int checks = 0;
  int fails = 0;
  int resyncs = 0;
  int wide_pulses = 0;
  bit prev_rs = 1'b0;
  bit toggling = 1'b0;

  typedef struct packed { logic bclk; logic fclk; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  audio_clk_gen u0 (
    .clk(clk), .rst_n(rst_n), .master_sel(master_sel), .fclk_in(fclk_in),
    .mclk_out(mclk_out), .bclk_out(bclk_out), .fclk_out(fclk_out),
    .err(err), .clk_lost(clk_lost), .resync_req(resync_req)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Monitor: pops expected clock levels and counts request pulses.
  always @(negedge clk) begin
    if (rst_n) begin
      if (resync_req) begin
        resyncs++;
        if (prev_rs) wide_pulses++;
      end
      prev_rs = resync_req;
    end else begin
      prev_rs = 1'b0;
    end
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      chk(bclk_out == it.bclk, "R1 bclk", bclk_out, it.bclk);
      chk(fclk_out == it.fclk, "R1/R2 fclk", fclk_out, it.fclk);
      chk(!err && !clk_lost, "R9 master err", {err, clk_lost}, 0);
    end
  end

  // Noise on the slave input while in master mode.
  initial begin
    forever begin
      repeat (37) @(negedge clk);
      if (toggling) fclk_in = ~fclk_in;
    end
  end

  task automatic do_reset(input bit mode);
    @(negedge clk);
    rst_n = 1'b0;
    master_sel = mode;
    fclk_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic frame(input int p);
    fclk_in = 1'b1;
    repeat (p / 2) @(negedge clk);
    fclk_in = 1'b0;
    repeat (p - p / 2) @(negedge clk);
  endtask

  // Driver for the master-mode scoreboard.
  task automatic drive_master(input int n_cycles);
    for (int n = 1; n <= n_cycles; n++) begin
      exp_t e;
      int c;
      @(posedge clk);
      #1;
      c = n % 256;
      e.bclk = ((c % 4) >= 2);
      e.fclk = (c < 128);
      q.push_back(e);
    end
    @(negedge clk);
    #1;
  endtask

  initial begin
    int rs0;
    // Master mode: reset state, then scoreboard.
    master_sel = 1'b1;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(fclk_out == 1 && bclk_out == 0, "R1 reset levels", {bclk_out, fclk_out}, 1);
    chk(err == 0, "R9 reset err master", err, 0);
    rst_n = 1'b1;
    toggling = 1'b1;
    rs0 = resyncs;
    drive_master(600);
    toggling = 1'b0;
    chk(resyncs == rs0, "R9 no requests", resyncs, rs0);
    @(posedge clk); #2;
    chk(mclk_out == 1, "R3 mclk high master", mclk_out, 1);
    @(negedge clk); #2;
    chk(mclk_out == 0, "R3 mclk low phase", mclk_out, 0);

    // Slave mode.
    do_reset(1'b0);
    #1;
    chk(err == 1, "R4 err after reset", err, 1);
    chk(bclk_out == 0 && fclk_out == 0, "R3 slave outputs low", {bclk_out, fclk_out}, 0);
    @(posedge clk); #2;
    chk(mclk_out == 0, "R3 mclk low slave", mclk_out, 0);
    @(negedge clk);
    rs0 = resyncs;
    frame(256); frame(256);
    chk(err == 1, "R5 one good frame", err, 1);
    frame(256);
    chk(err == 0, "R5 locked after two", err, 0);
    frame(266); frame(256);
    chk(err == 0 && resyncs == rs0, "R6 plus ten tolerated", err, 0);
    frame(267); frame(256);
    chk(err == 1, "R7 plus eleven err", err, 1);
    chk(resyncs == rs0 + 1, "R7 plus eleven request", resyncs, rs0 + 1);
    frame(256);
    chk(err == 1, "R7 one frame after slip", err, 1);
    frame(256);
    chk(err == 0, "R7 relocked", err, 0);
    frame(245); frame(256);
    chk(err == 1 && resyncs == rs0 + 2, "R7 minus eleven", resyncs, rs0 + 2);
    frame(256); frame(256);
    chk(err == 0, "R7 relock after minus", err, 0);
    frame(246); frame(256);
    chk(err == 0 && resyncs == rs0 + 2, "R6 minus ten tolerated", resyncs, rs0 + 2);
    chk(clk_lost == 0, "R8 no loss yet", clk_lost, 0);
    repeat (600) @(negedge clk);
    chk(clk_lost == 1, "R8 loss flagged", clk_lost, 1);
    chk(err == 1, "R8 loss err", err, 1);
    chk(resyncs == rs0 + 3, "R8 loss request", resyncs, rs0 + 3);
    frame(256);
    chk(clk_lost == 0, "R8 loss cleared", clk_lost, 0);
    frame(256);
    chk(err == 1, "R8 new reference only", err, 1);
    frame(256);
    chk(err == 0, "R5 relock after loss", err, 0);
    chk(wide_pulses == 0, "R7 pulse width", wide_pulses, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule